// File: doc/BRIEF.md
# Rectangle Fill Raster Engine

This block paints a solid axis-aligned rectangle into a frame buffer that holds one 32-bit word per pixel. A host programs a small set of word-wide registers: primitive code, fill colour, raster operation, top edge, left edge, height and width. The width write is the trigger. If the primitive code selects a filled rectangle at that moment, the engine takes a copy of the whole setup and walks the area top row first, left to right within each row. It sends one memory access per pixel, or two when the raster operation needs the old pixel value.

The frame-buffer port is a single request channel with a valid/ready handshake. A read request gets its data in the same cycle that ready accepts it. The colour register holds red in bits 7:0, green in 15:8 and blue in 23:16, and that word is written to memory unchanged. The word address of pixel (x, y) is y*LINE_PITCH + x.

Top module: `rectFillEngine`

## Requirements
- R1: Host register selects are: 0 primitive code, 1 colour, 2 raster op, 3 top edge Y, 4 left edge X, 5 height, 6 width. Writing select 6 while idle, with primitive code 0x08 and a nonzero width and height, starts a fill, and `busy` is high in the cycle after that write.
- R2: A width write while the primitive code is anything other than 0x08 starts nothing: `busy` stays low and no memory request is made.
- R3: A fill writes every pixel of the rectangle exactly once, at address (Y+row)*LINE_PITCH + X+col. Rows go in increasing order, and columns go left to right within each row.
- R4: Raster op 0x83 writes the colour register value and makes no read requests.
- R5: Raster op 0x85 reads each pixel and then writes back the value it read. Each write immediately follows the read of the same pixel.
- R6: Raster op 0x86 reads each pixel and writes the colour XOR the value read.
- R7: Any raster-op code other than 0x83, 0x85 and 0x86 behaves like 0x83.
- R8: A width or height of zero completes at once: `busy` never rises and no memory request is made.
- R9: `busy` stays high until the last pixel write is accepted, and it is low in the following cycle along with `memValid`.
- R10: While `memValid` is high and `memReady` is low, the request (`memWe`, `memAddr`, `memWdata`) holds steady. Read data is taken in the cycle that `memReady` accepts the read.
- R11: Register writes made during a fill do not change that fill. A width write made during a fill does not start a second one.
- R12: After reset, `busy` and `memValid` are low and the raster op is 0x83, with colour 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Register select |
| hostWrData | input | 32 | Register write data |
| busy | output | 1 | Fill in progress |
| memValid | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write request, 0 = read request |
| memAddr | output | ADDR_W | Pixel word address |
| memWdata | output | 32 | Pixel write data |
| memRdata | input | 32 | Read data, valid while a read is accepted |
| memReady | input | 1 | Memory accepts the current request |

## Verification
The embedded assertions check on every cycle that a stalled request holds steady and that every accepted read is followed directly by a write. They also check that a copy fill never issues a read, that the walk counters stay inside the latched rectangle, and that a zero-width trigger leaves the engine idle. Only the bench scenarios can show that the right pixels end up with the right values in the right order. These scenarios also show the write and read counts for each raster op, the moment `busy` falls, and that setup changes made mid-fill are ignored. Ready is thrown randomly, so stalls fall on reads, writes and the row turns.

// File: rtl/rectfill_pkg.sv
package rectfill_pkg;

  localparam int PIX_W     = 32;
  localparam int REG_SEL_W = 3;

  localparam logic [7:0] OP_RECT = 8'h08;
  localparam logic [7:0] ROP_NEW = 8'h83;
  localparam logic [7:0] ROP_OLD = 8'h85;
  localparam logic [7:0] ROP_XOR = 8'h86;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_OPCODE = 3'd0,
    SEL_COLOR  = 3'd1,
    SEL_ROP    = 3'd2,
    SEL_TOPY   = 3'd3,
    SEL_LEFTX  = 3'd4,
    SEL_HEIGHT = 3'd5,
    SEL_WIDTH  = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } fillState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // latch setup, reset walk counters
    logic capture;  // take read data
    logic advance;  // step to next pixel
    logic active;   // a request is on the port
  } fillStrobes_t;

  function automatic logic ropNeedsOld(input logic [7:0] rop);
    return (rop == ROP_OLD) || (rop == ROP_XOR);
  endfunction

  function automatic logic [PIX_W-1:0] applyRop(input logic [7:0] rop,
                                                input logic [PIX_W-1:0] newPix,
                                                input logic [PIX_W-1:0] oldPix);
    case (rop)
      ROP_OLD: return oldPix;
      ROP_XOR: return newPix ^ oldPix;
      default: return newPix;
    endcase
  endfunction

endpackage

// File: rtl/rectfill_datapath.sv
module rectfill_datapath
  import rectfill_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int ADDR_W     = 24,
  parameter int LINE_PITCH = 2048
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [REG_SEL_W-1:0] hostAddr,
  input  logic [PIX_W-1:0]     hostWrData,
  input  fillStrobes_t         strobe,
  input  logic                 fillIdle,
  input  logic                 memReady,
  input  logic [PIX_W-1:0]     memRdata,
  output logic                 startGo,
  output logic                 startNeedsRead,
  output logic                 needReadLat,
  output logic                 lastPixel,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [PIX_W-1:0]     memWdata
);

  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  // host-visible setup registers
  logic [7:0]         opReg, ropReg;
  logic [PIX_W-1:0]   colorReg;
  logic [COORD_W-1:0] topReg, leftReg, heightReg, widthReg;

  // latched fill setup and walk state
  logic [7:0]         ropLat;
  logic [PIX_W-1:0]   colorLat, oldPix;
  logic [COORD_W-1:0] wLat, hLat, colCnt, rowCnt;
  logic [ADDR_W-1:0]  rowAddr;

  logic widthWrite;
  logic [COORD_W-1:0] newWidth;

  assign widthWrite = hostWrEn && (hostAddr == SEL_WIDTH);
  assign newWidth   = hostWrData[COORD_W-1:0];

  assign startGo = widthWrite && fillIdle && (opReg == OP_RECT)
                   && (newWidth != '0) && (heightReg != '0);
  assign startNeedsRead = ropNeedsOld(ropReg);
  assign needReadLat    = ropNeedsOld(ropLat);

  assign lastPixel = (colCnt == wLat - ONE) && (rowCnt == hLat - ONE);
  assign memAddr   = rowAddr + ADDR_W'(colCnt);
  assign memWdata  = applyRop(ropLat, colorLat, oldPix);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= '0;
      ropReg    <= ROP_NEW;
      colorReg  <= '0;
      topReg    <= '0;
      leftReg   <= '0;
      heightReg <= '0;
      widthReg  <= '0;
    end else if (hostWrEn) begin
      case (hostAddr)
        SEL_OPCODE: opReg     <= hostWrData[7:0];
        SEL_COLOR:  colorReg  <= hostWrData;
        SEL_ROP:    ropReg    <= hostWrData[7:0];
        SEL_TOPY:   topReg    <= hostWrData[COORD_W-1:0];
        SEL_LEFTX:  leftReg   <= hostWrData[COORD_W-1:0];
        SEL_HEIGHT: heightReg <= hostWrData[COORD_W-1:0];
        SEL_WIDTH:  widthReg  <= newWidth;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ropLat   <= ROP_NEW;
      colorLat <= '0;
      oldPix   <= '0;
      wLat     <= '0;
      hLat     <= '0;
      colCnt   <= '0;
      rowCnt   <= '0;
      rowAddr  <= '0;
    end else begin
      if (strobe.load) begin
        ropLat   <= ropReg;
        colorLat <= colorReg;
        wLat     <= newWidth;
        hLat     <= heightReg;
        colCnt   <= '0;
        rowCnt   <= '0;
        rowAddr  <= ADDR_W'(topReg) * ADDR_W'(LINE_PITCH) + ADDR_W'(leftReg);
      end else if (strobe.advance) begin
        if (colCnt == wLat - ONE) begin
          colCnt  <= '0;
          rowCnt  <= rowCnt + ONE;
          rowAddr <= rowAddr + ADDR_W'(LINE_PITCH);
        end else begin
          colCnt <= colCnt + ONE;
        end
      end
      if (strobe.capture) oldPix <= memRdata;
    end
  end

  AST_REQ_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active && !memReady |=> $stable(memAddr) && $stable(memWdata)); // R10
  AST_WALK_IN_RECT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |-> (colCnt < wLat) && (rowCnt < hLat)); // R3
  AST_ZERO_SIZE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    widthWrite && fillIdle && (newWidth == '0) |=> fillIdle); // R8

endmodule

// File: rtl/rectfill_ctrl.sv
module rectfill_ctrl
  import rectfill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startGo,
  input  logic         startNeedsRead,
  input  logic         needReadLat,
  input  logic         lastPixel,
  input  logic         memReady,
  output fillStrobes_t strobe,
  output logic         fillIdle,
  output logic         memValid,
  output logic         memWe,
  output logic         busy
);

  fillState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (startGo) stateD = startNeedsRead ? ST_READ : ST_WRITE;
      ST_READ:  if (memReady) stateD = ST_WRITE;
      ST_WRITE: if (memReady) begin
                  if (lastPixel)        stateD = ST_IDLE;
                  else if (needReadLat) stateD = ST_READ;
                  else                  stateD = ST_WRITE;
                end
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign fillIdle       = (stateQ == ST_IDLE);
  assign strobe.load    = fillIdle && startGo;
  assign strobe.active  = !fillIdle;
  assign strobe.capture = (stateQ == ST_READ) && memReady;
  assign strobe.advance = (stateQ == ST_WRITE) && memReady;

  assign memValid = !fillIdle;
  assign memWe    = (stateQ == ST_WRITE);
  assign busy     = !fillIdle;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && (memWe == $past(memWe))); // R10
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !memWe |=> memValid && memWe); // R5
  AST_COPY_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !needReadLat |-> memWe); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    fillIdle && startGo |=> busy); // R1

endmodule

// File: rtl/rectFillEngine.sv
module rectFillEngine
  import rectfill_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int ADDR_W     = 24,
  parameter int LINE_PITCH = 2048
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [REG_SEL_W-1:0] hostAddr,
  input  logic [PIX_W-1:0]     hostWrData,
  output logic                 busy,
  output logic                 memValid,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [PIX_W-1:0]     memWdata,
  input  logic [PIX_W-1:0]     memRdata,
  input  logic                 memReady
);

  fillStrobes_t strobe;
  logic fillIdle, startGo, startNeedsRead, needReadLat, lastPixel;

  rectfill_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .startGo        (startGo),
    .startNeedsRead (startNeedsRead),
    .needReadLat    (needReadLat),
    .lastPixel      (lastPixel),
    .memReady       (memReady),
    .strobe         (strobe),
    .fillIdle       (fillIdle),
    .memValid       (memValid),
    .memWe          (memWe),
    .busy           (busy)
  );

  rectfill_datapath #(
    .COORD_W    (COORD_W),
    .ADDR_W     (ADDR_W),
    .LINE_PITCH (LINE_PITCH)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .hostWrEn       (hostWrEn),
    .hostAddr       (hostAddr),
    .hostWrData     (hostWrData),
    .strobe         (strobe),
    .fillIdle       (fillIdle),
    .memReady       (memReady),
    .memRdata       (memRdata),
    .startGo        (startGo),
    .startNeedsRead (startNeedsRead),
    .needReadLat    (needReadLat),
    .lastPixel      (lastPixel),
    .memAddr        (memAddr),
    .memWdata       (memWdata)
  );

endmodule

// File: tb/rectFillEngine_tb.sv
module rectFillEngine_tb;

  localparam int PITCH = 64;
  localparam int AW    = 12;
  localparam int CW    = 12;
  localparam int MEMW  = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic          hostWrEn;
  logic [2:0]    hostAddr;
  logic [31:0]   hostWrData;
  logic          busy, memValid, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata, memRdata;
  logic          memReady;

  rectFillEngine #(.COORD_W(CW), .ADDR_W(AW), .LINE_PITCH(PITCH)) u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .busy(busy), .memValid(memValid), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  logic [31:0] fbMem  [MEMW];
  logic [31:0] expMem [MEMW];

  int checks = 0, errors = 0;
  int writesSeen, readsSeen, orderErr;
  int expRow, expCol, curX, curY, curW;
  int readyPct = 100;
  bit finished = 0;

  assign memRdata = fbMem[memAddr];

  // memory model and write-order monitor
  always @(posedge clk) begin
    if (rstN && memValid && memReady) begin
      if (memWe) begin
        fbMem[memAddr] <= memWdata;
        writesSeen++;
        if (int'(memAddr) != (curY + expRow) * PITCH + curX + expCol) orderErr++;
        expCol++;
        if (expCol >= curW) begin expCol = 0; expRow++; end
      end else begin
        readsSeen++;
      end
    end
  end

  always @(negedge clk) memReady = (($urandom % 100) < readyPct);

  function automatic logic [31:0] ropModel(input logic [7:0] rop, input logic [31:0] n,
                                           input logic [31:0] o);
    if (rop == 8'h85) return o;
    if (rop == 8'h86) return n ^ o;
    return n;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  // program everything but width; build expected image
  task automatic setupFill(input logic [7:0] op, input int y, input int x, input int h,
                           input int w, input logic [31:0] fg, input logic [7:0] rop);
    hostWrite(3'd0, {24'd0, op});
    hostWrite(3'd1, fg);
    hostWrite(3'd2, {24'd0, rop});
    hostWrite(3'd3, y);
    hostWrite(3'd4, x);
    hostWrite(3'd5, h);
    curX = x; curY = y; curW = w; expRow = 0; expCol = 0;
    writesSeen = 0; readsSeen = 0; orderErr = 0;
    if (op == 8'h08)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          expMem[(y + r) * PITCH + x + c] = ropModel(rop, fg, expMem[(y + r) * PITCH + x + c]);
  endtask

  task automatic finishFill(input string tag, input int expWrites, input int expReads);
    int mism = 0, firstBad = -1;
    while (busy) @(negedge clk);
    chk(memValid == 1'b0, "R9 memValid low once busy falls", memValid, 0);
    repeat (3) @(negedge clk);
    chk(writesSeen == expWrites, {tag, " write count"}, writesSeen, expWrites);
    chk(readsSeen == expReads, {tag, " read count"}, readsSeen, expReads);
    chk(orderErr == 0, "R3 write address order", orderErr, 0);
    for (int i = 0; i < MEMW; i++)
      if (fbMem[i] !== expMem[i]) begin mism++; if (firstBad < 0) firstBad = i; end
    if (mism != 0)
      chk(0, {tag, " frame contents"}, fbMem[firstBad], expMem[firstBad]);
    else
      chk(1, {tag, " frame contents"}, 0, 0);
  endtask

  task automatic runFill(input string tag, input logic [7:0] op, input int y, input int x,
                         input int h, input int w, input logic [31:0] fg, input logic [7:0] rop);
    bit starts = (op == 8'h08) && (w != 0) && (h != 0);
    bit rd = starts && ((rop == 8'h85) || (rop == 8'h86));
    setupFill(op, y, x, h, w, fg, rop);
    hostWrite(3'd6, w);
    chk(busy == starts, "R1 busy after width write", busy, starts);
    finishFill(tag, starts ? w * h : 0, rd ? w * h : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    hostWrEn = 0; hostAddr = 0; hostWrData = 0; rstN = 0;
    for (int i = 0; i < MEMW; i++) begin
      fbMem[i] = $urandom; expMem[i] = fbMem[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(busy == 0, "R12 busy after reset", busy, 0);
    chk(memValid == 0, "R12 memValid after reset", memValid, 0);

    // R12: default raster op is copy and colour 0
    curX = 5; curY = 2; curW = 3; expRow = 0; expCol = 0;
    writesSeen = 0; readsSeen = 0; orderErr = 0;
    hostWrite(3'd0, 32'h08); hostWrite(3'd3, 2); hostWrite(3'd4, 5); hostWrite(3'd5, 2);
    for (int r = 0; r < 2; r++) for (int c = 0; c < 3; c++) expMem[(2 + r) * PITCH + 5 + c] = 0;
    hostWrite(3'd6, 3);
    finishFill("R12 default rop copy", 6, 0);

    readyPct = 60;
    runFill("R4 copy",        8'h08, 10, 3, 4, 5, 32'h00AB_CD12, 8'h83);
    runFill("R5 keep old",    8'h08, 20, 40, 3, 6, 32'h00FF_FFFF, 8'h85);
    runFill("R6 xor",         8'h08, 30, 10, 5, 7, 32'h0012_3456, 8'h86);
    runFill("R7 unknown rop", 8'h08, 40, 20, 2, 4, 32'h0077_0011, 8'h5A);
    runFill("R2 other opcode", 8'h0A, 5, 5, 3, 3, 32'h0011_2233, 8'h83);
    runFill("R8 zero width",  8'h08, 5, 5, 3, 0, 32'h0044_5566, 8'h86);
    runFill("R8 zero height", 8'h08, 5, 5, 0, 4, 32'h0044_5566, 8'h83);
    readyPct = 100;
    runFill("R3 single pixel", 8'h08, 63, 63, 1, 1, 32'h00C0_FFEE, 8'h86);
    runFill("R3 full row",    8'h08, 0, 0, 1, 64, 32'h0001_0203, 8'h83);

    // R11: setup changes and a second trigger during a fill are ignored
    readyPct = 50;
    setupFill(8'h08, 44, 8, 6, 9, 32'h00AA_5500, 8'h86);
    hostWrite(3'd6, 9);
    chk(busy == 1, "R11 fill started", busy, 1);
    hostWrite(3'd1, 32'h0000_00FF);
    hostWrite(3'd2, 32'h85);
    hostWrite(3'd3, 1);
    hostWrite(3'd6, 2);
    finishFill("R11 mid-fill writes ignored", 54, 54);

    // R10/R3: random fills with random stalls
    for (int k = 0; k < 24; k++) begin
      int h = $urandom % 8;
      int w = $urandom % 10;
      int y = $urandom % (64 - h);
      int x = $urandom % (64 - w);
      int pick = $urandom % 4;
      logic [7:0] rop = (pick == 0) ? 8'h83 : (pick == 1) ? 8'h85 :
                        (pick == 2) ? 8'h86 : 8'(8'h10 + ($urandom % 8));
      readyPct = 40 + ($urandom % 61);
      runFill("R10 random fill", 8'h08, y, x, h, w, $urandom, rop);
    end

    report();
  end

endmodule